// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 64-bit virtual address into a physical page address by reading a tree of page tables held in memory. It is meant for a debug agent that has already missed in the translation cache. A request carries the virtual address and a debug flag. Only a debug request starts a walk. Any other request returns a no-match fault at once.

The walk starts from one of two root-table bases, picked by the top address bit. It then goes down through up to four directory levels. The shift and index width of each level are configuration inputs, so a level set to zero width is passed over. The walk ends either with a leaf lookup or early, on a huge-page directory word. A huge word is rewritten into an ordinary leaf entry. The final entry then gives the validity, the write permission and the physical address, with the in-page offset added and the attribute bits removed.

Memory reads go out on a request port with a valid/ready handshake. Read data comes back on a response strobe. Every bit position of the entry fields is a parameter.

Top module: `pt_walker`

## Requirements
- R1: Virtual address bit 63 picks the root base: `root_hi` when 1, `root_lo` when 0. The chosen base is masked to the low PA_W (default 48) bits.
- R2: Directory levels are visited from level 4 down to level 1. A level whose configured width is 0 produces no memory read.
- R3: The read address for a level is the current base ORed with ((vaddr >> shift) & (2^width - 1)) << 3.
- R4: A word read at a directory level is masked to PA_W bits and becomes the base of the next level.
- R5: A masked directory word with bit HUGE_BIT (default 6) set ends the walk and becomes the final entry. In that entry the LEVEL field (default bits 14:13) and the HUGE bit are cleared. If HGLOBAL_BIT (default 12) is set, that bit is cleared and G_BIT (default 6) is set.
- R6: A walk that meets no huge word makes one further leaf read, using the level-0 shift and width. The full unmasked 64-bit word read there is the final entry.
- R7: A final entry with V_BIT (default 0) clear gives `done_fault`=1, `done_wr`=0 and `done_pa`=0.
- R8: For a valid entry, `done_wr` equals its D_BIT (default 1).
- R9: For a valid entry, `done_pa` is formed in three steps. First add (vaddr & PA mask & (2^s - 1)) to the entry, where s is the shift of the level the final entry came from. Then clear bits RPLV_BIT, NX_BIT and NR_BIT (defaults 63, 62, 61). Finally clear the low PAGE_SHIFT (default 12) bits.
- R10: A request with `req_debug`=0 makes no memory read. Its `done` with `done_fault`=1 appears in the cycle right after acceptance.
- R11: `done` is high for exactly one cycle per request. `req_ready` is high only while the walker is idle and `done` is low.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_debug | input | 1 | Debug access; only these start a walk |
| root_lo | input | 64 | Root table base for the low half |
| root_hi | input | 64 | Root table base for the high half |
| cfg_shift | input | 5*SH_W | Per-level index shift, level 0 in the low slice |
| cfg_width | input | 5*WD_W | Per-level index width, level 0 in the low slice |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | PA_W | Byte address of the 64-bit read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | Result strobe, one cycle |
| done_pa | output | 64 | Physical page address |
| done_wr | output | 1 | Write permitted (read is always permitted unless faulted) |
| done_fault | output | 1 | No-match fault |

## Verification
A non-debug request is accepted on a clock edge, and its fault result is registered on that same edge. The bench therefore samples `done` at the falling edge just after acceptance and requires it there. A debug walk takes a variable number of cycles, because it depends on skipped levels, memory-ready gaps and response latency. For a walk the bench first checks that `req_ready` has dropped at that same falling edge. It then polls `done` at every falling edge. On the first edge where `done` is high it compares the outputs and the number of memory reads with a behavioural model. It checks again one edge later that `done` has fallen.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W        = 48,
  parameter int SH_W        = 6,
  parameter int WD_W        = 5,
  parameter int TOP_LVL     = 4,
  parameter int PAGE_SHIFT  = 12,
  parameter int V_BIT       = 0,
  parameter int D_BIT       = 1,
  parameter int G_BIT       = 6,
  parameter int HUGE_BIT    = 6,
  parameter int HGLOBAL_BIT = 12,
  parameter int LEVEL_LSB   = 13,
  parameter int LEVEL_W     = 2,
  parameter int RPLV_BIT    = 63,
  parameter int NX_BIT      = 62,
  parameter int NR_BIT      = 61
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [63:0]                   req_vaddr,
  input  logic                          req_debug,
  input  logic [63:0]                   root_lo,
  input  logic [63:0]                   root_hi,
  input  logic [(TOP_LVL+1)*SH_W-1:0]   cfg_shift,
  input  logic [(TOP_LVL+1)*WD_W-1:0]   cfg_width,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic [PA_W-1:0]               mem_req_addr,
  input  logic                          mem_rsp_valid,
  input  logic [63:0]                   mem_rsp_data,
  output logic                          done,
  output logic [63:0]                   done_pa,
  output logic                          done_wr,
  output logic                          done_fault
);
  localparam int LV_W = $clog2(TOP_LVL + 1);
  localparam logic [63:0] PMASK = (64'd1 << PA_W) - 64'd1;

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_ISSUE, S_WAIT, S_EVAL} st_t;

  st_t             st;
  logic [LV_W-1:0] lvl;
  logic [63:0]     base, va, entry, fin;
  logic [SH_W-1:0] used_sh;

  wire [SH_W-1:0] cur_sh = cfg_shift[lvl*SH_W +: SH_W];
  wire [WD_W-1:0] cur_wd = cfg_width[lvl*WD_W +: WD_W];
  wire [63:0]     idx    = (va >> cur_sh) & ((64'd1 << cur_wd) - 64'd1);
  wire [63:0]     dword  = mem_rsp_data & PMASK;

  assign mem_req_valid = (st == S_ISSUE);
  assign mem_req_addr  = PA_W'(base | (idx << 3));
  assign req_ready     = (st == S_IDLE) && !done;

  function automatic logic [63:0] unhuge(input logic [63:0] w);
    logic [63:0] r;
    r = w;
    r[LEVEL_LSB +: LEVEL_W] = '0;
    r[HUGE_BIT] = 1'b0;
    if (w[HGLOBAL_BIT]) begin
      r[HGLOBAL_BIT] = 1'b0;
      r[G_BIT]       = 1'b1;
    end
    return r;
  endfunction

  always_comb begin
    fin = entry + (va & PMASK & ((64'd1 << used_sh) - 64'd1));
    fin[RPLV_BIT] = 1'b0;
    fin[NX_BIT]   = 1'b0;
    fin[NR_BIT]   = 1'b0;
    fin[PAGE_SHIFT-1:0] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      lvl        <= '0;
      base       <= '0;
      va         <= '0;
      entry      <= '0;
      used_sh    <= '0;
      done       <= 1'b0;
      done_pa    <= '0;
      done_wr    <= 1'b0;
      done_fault <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid && req_ready) begin
          va <= req_vaddr;
          if (!req_debug) begin
            done       <= 1'b1;
            done_fault <= 1'b1;
            done_wr    <= 1'b0;
            done_pa    <= '0;
          end else begin
            base <= (req_vaddr[63] ? root_hi : root_lo) & PMASK;
            lvl  <= LV_W'(TOP_LVL);
            st   <= S_SEL;
          end
        end
        S_SEL: begin
          if (lvl != '0 && cur_wd == '0) lvl <= lvl - LV_W'(1);
          else st <= S_ISSUE;
        end
        S_ISSUE: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (lvl != '0) begin
            if (dword[HUGE_BIT]) begin
              entry   <= unhuge(dword);
              used_sh <= cur_sh;
              st      <= S_EVAL;
            end else begin
              base <= dword;
              lvl  <= lvl - LV_W'(1);
              st   <= S_SEL;
            end
          end else begin
            entry   <= mem_rsp_data;
            used_sh <= cur_sh;
            st      <= S_EVAL;
          end
        end
        S_EVAL: begin
          done       <= 1'b1;
          done_fault <= !entry[V_BIT];
          done_wr    <= entry[V_BIT] & entry[D_BIT];
          done_pa    <= entry[V_BIT] ? fin : 64'd0;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_nodebug_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_debug |=> done && done_fault);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_page_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_fault |-> done_pa[PAGE_SHIFT-1:0] == '0);

  p_attr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_fault |-> !done_pa[RPLV_BIT] && !done_pa[NX_BIT] && !done_pa[NR_BIT]);

  p_fault_nowr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_fault |-> !done_wr && done_pa == 64'd0);
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  localparam int PA_W = 48;
  localparam logic [63:0] PM = (64'd1 << PA_W) - 64'd1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_debug = 0;
  logic [63:0] req_vaddr = '0, root_lo = 64'h10000, root_hi = 64'h20000;
  logic [29:0] cfg_shift;
  logic [24:0] cfg_width;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic [63:0] mem_rsp_data = '0;
  logic req_ready, mem_req_valid, done, done_wr, done_fault;
  logic [PA_W-1:0] mem_req_addr;
  logic [63:0] done_pa;

  int errors = 0, checks = 0, reads = 0;
  int sh [5] = '{12, 21, 30, 39, 48};
  int wd [5] = '{9, 9, 9, 0, 0};
  logic [63:0] mem [logic [63:0]];

  always #4 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_debug(req_debug), .root_lo(root_lo), .root_hi(root_hi),
    .cfg_shift(cfg_shift), .cfg_width(cfg_width), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_pa(done_pa), .done_wr(done_wr),
    .done_fault(done_fault));

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  task automatic apply_cfg();
    for (int l = 0; l < 5; l++) begin
      cfg_shift[l*6 +: 6] = 6'(sh[l]);
      cfg_width[l*5 +: 5] = 5'(wd[l]);
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] va, input bit dbg, output logic [63:0] pa,
                                output bit wr, output bit flt, output int n);
    logic [63:0] b, e, idx;
    int s;
    bit huge;
    n = 0; pa = 0; wr = 0; flt = 1;
    if (!dbg) return;
    b = (va[63] ? root_hi : root_lo) & PM;
    s = 0; huge = 0;
    for (int l = 4; l > 0; l--) begin
      if (wd[l] == 0) continue;
      idx = (va >> sh[l]) & ((64'd1 << wd[l]) - 1);
      b = rd(b | (idx << 3)) & PM;
      n++; s = sh[l];
      if (b[6]) begin huge = 1; break; end
    end
    if (huge) begin
      e = b; e[14:13] = 0; e[6] = 0;
      if (e[12]) begin e[12] = 0; e[6] = 1; end
    end else begin
      idx = (va >> sh[0]) & ((64'd1 << wd[0]) - 1);
      e = rd(b | (idx << 3)); n++; s = sh[0];
    end
    flt = !e[0];
    if (flt) return;
    wr = e[1];
    pa = e + (va & PM & ((64'd1 << s) - 1));
    pa[63] = 0; pa[62] = 0; pa[61] = 0; pa[11:0] = 0;
  endfunction

  initial forever begin
    int dly;
    logic [63:0] a;
    bit pend;
    @(negedge clk);
    mem_rsp_valid = 0;
    mem_req_ready = 0;
    if (pend) begin
      dly--;
      if (dly == 0) begin mem_rsp_valid = 1; mem_rsp_data = rd(a); pend = 0; end
    end else if (mem_req_valid && ($urandom % 3 != 0)) begin
      mem_req_ready = 1; pend = 1; a = 64'(mem_req_addr); dly = 1 + $urandom % 3; reads++;
    end
  end

  task automatic run(input logic [63:0] va, input bit dbg, input string req);
    logic [63:0] epa; bit ewr, eflt; int en, cyc;
    model(va, dbg, epa, ewr, eflt, en);
    reads = 0;
    @(negedge clk);
    req_vaddr = va; req_debug = dbg; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (!dbg) chk(done === 1'b1, {req, " R10 done next cycle"}, 64'(done), 64'd1);
    else chk(req_ready === 1'b0, {req, " R11 busy"}, 64'(req_ready), 64'd0);
    cyc = 0;
    while (done !== 1'b1 && cyc < 2000) begin @(negedge clk); cyc++; end
    chk(done_fault === eflt, {req, " fault"}, 64'(done_fault), 64'(eflt));
    if (!eflt) begin
      chk(done_pa === epa, {req, " pa"}, done_pa, epa);
      chk(done_wr === ewr, {req, " wr"}, 64'(done_wr), 64'(ewr));
    end
    chk(reads == en, {req, " read count"}, 64'(reads), 64'(en));
    @(negedge clk);
    chk(done === 1'b0, {req, " R11 one-cycle done"}, 64'(done), 64'd0);
  endtask

  initial begin
    #(8ns * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    apply_cfg();
    // R1 R3 R4 R6: low-half, 3-level walk (levels 4,3 skipped: R2)
    mem[64'h10000 | (64'd1 << 3)] = 64'hABCD_0000_0003_0000;
    mem[64'h30000 | (64'd3 << 3)] = 64'h0000_0000_0003_1000;
    mem[64'h31000 | (64'd3 << 3)] = 64'h4000_0000_8765_402F;
    // R1 R8: high-half, D clear
    mem[64'h20000 | (64'd0 << 3)] = 64'h0000_0000_0003_2000;
    mem[64'h32000 | (64'd1 << 3)] = 64'h0000_0000_0003_3000;
    mem[64'h33000 | (64'd1 << 3)] = 64'h0000_0000_1111_1001;
    // R5: huge at level 1 with HGLOBAL and LEVEL bits
    mem[64'h10000 | (64'd2 << 3)] = 64'h0000_0000_0003_4000;
    mem[64'h34000 | (64'd0 << 3)] = 64'h0000_0000_C020_3043;
    // R5: huge at level 2, no HGLOBAL
    mem[64'h10000 | (64'd5 << 3)] = 64'h0000_0000_4000_4043;
    // R7: invalid leaf
    mem[64'h10000 | (64'd6 << 3)] = 64'h0000_0000_0003_5000;
    mem[64'h35000 | (64'd0 << 3)] = 64'h0000_0000_0003_6000;
    mem[64'h36000 | (64'd0 << 3)] = 64'h0000_0000_9999_9002;
    // R9: attribute bits set, high bit passes
    mem[64'h36000 | (64'd1 << 3)] = 64'hA004_0000_7777_7003;
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && mem_req_valid === 1'b0, "reset R11 outputs idle", 64'(done), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1, "reset R11 ready", 64'(req_ready), 64'd1);

    run(64'h0000_0000_4060_3ABC, 1, "R1 R3 R4 R6 low-half walk");
    run(64'h8000_0000_0020_1123, 1, "R1 R8 high-half read-only");
    run(64'h0000_0000_8012_3456, 1, "R5 huge level1 hglobal");
    run(64'h0000_0001_4ABC_DEF0, 1, "R5 R9 huge level2");
    run(64'h0000_0001_8000_0000, 1, "R7 invalid leaf");
    run(64'h0000_0001_8000_1FFF, 1, "R9 attribute clear");
    run(64'h0000_0007_0000_0000, 1, "R7 unmapped");
    run(64'h0000_0000_4060_3ABC, 0, "R10 non-debug");
    run(64'h8000_0000_0020_1123, 0, "R10 non-debug high");

    // R2: enable level 3; table at level 3 now in path
    wd[3] = 9; apply_cfg();
    mem[64'h10000 | (64'd0 << 3)] = 64'h0000_0000_0003_7000;
    mem[64'h37000 | (64'd1 << 3)] = 64'h0000_0000_0003_8000;
    mem[64'h38000 | (64'd2 << 3)] = 64'h0000_0000_0003_9000;
    mem[64'h39000 | (64'd4 << 3)] = 64'h0000_0000_5555_5003;
    run(64'h0000_0000_4040_4321, 1, "R2 R12 four-read walk");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule